// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block handles data hazards for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). The pipeline includes a post-increment load. That load writes the loaded word to its destination register and also writes its base register plus a fixed step back to the base register. So each instruction in flight can carry two destinations: a primary one (`rd`) and an increment one (the base register).

The block compares the execute-stage source register numbers with the destinations held in the EX/MEM and MEM/WB pipeline registers. It selects, for each ALU operand, which value to use and drives the selected operand value out. It also contains the dedicated increment adder, which adds the step to the already-forwarded base operand.

The block detects a load-use hazard between the load in execute and the instruction in decode. On such a hazard it raises the hold and bubble controls for the same cycle. It also holds the register file, which has two write ports. The register file returns zero for register 0 and passes a same-cycle write-back value straight through to the decode-stage reads.

All pins are plain control and datapath wires with no valid/ready handshake. Every pipeline stage advances under the control of the surrounding core, so there is no back-pressure path in this block.

Top module: `hzfw_top`

## Requirements
- R1: The EX/MEM register's primary destination is forwarded when `exm_rd_we` is set and `exm_rd` equals an execute source. In that case the select code is 1 and the operand equals `exm_rd_val`, and no stall is raised. This applies to operand A (`ex_rs1`, `fwd_a`) and operand B (`ex_rs2`, `fwd_b`).
- R2: The MEM/WB register's primary destination is forwarded when `mwb_rd_we` is set and `mwb_rd` equals a source. The select code is 3 and the operand equals `mwb_rd_val`.
- R3: A load-use hazard exists when `ex_is_load`, `ex_rd_we` and a nonzero `ex_rd` equal to `id_rs1` or `id_rs2` are all present. In that case `hold_pc`, `hold_ifid` and `ex_bubble` are all 1 in the same cycle; otherwise all three are 0.
- R4: The increment destination is forwarded with no stall. From EX/MEM (`exm_inc_rd`, `exm_inc_val`) the select code is 2; from MEM/WB (`mwb_inc_rd`, `mwb_inc_val`) the select code is 4. A decode source that matches only a load's increment destination raises no hold.
- R5: The priority order is fixed. EX/MEM wins over MEM/WB, and within one stage the primary destination wins over the increment destination.
- R6: Register 0 is never forwarded. When no forwarding applies, the select code is 0 and the operand equals `ex_rs1_val` or `ex_rs2_val`.
- R7: `ex_inc_val` always equals operand A after forwarding plus INC_STEP (4), computed with wrap-around.
- R8: Both register-file write ports commit at the rising clock edge. The written values are readable on `id_rdata1` and `id_rdata2` afterwards. Writes to register 0 are discarded, and register 0 always reads as zero.
- R9: A decode read of a register that a write port is writing in the same cycle returns the new value. This holds on both write ports. If both ports name the same register, the primary port's value wins.
- R10: Reset clears every register in the register file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_rs1 | input | 5 | Decode source 1 register number |
| id_rs2 | input | 5 | Decode source 2 register number |
| id_rdata1 | output | 32 | Register-file read for id_rs1 (with write-back pass-through) |
| id_rdata2 | output | 32 | Register-file read for id_rs2 (with write-back pass-through) |
| ex_rs1 | input | 5 | Execute source 1 register number |
| ex_rs2 | input | 5 | Execute source 2 register number |
| ex_rd | input | 5 | Execute primary destination |
| ex_rd_we | input | 1 | Execute primary destination is written |
| ex_is_load | input | 1 | Execute instruction reads memory |
| ex_rs1_val | input | 32 | Source 1 value latched in ID/EX |
| ex_rs2_val | input | 32 | Source 2 value latched in ID/EX |
| exm_rd | input | 5 | EX/MEM primary destination |
| exm_rd_we | input | 1 | EX/MEM primary write enable |
| exm_inc_rd | input | 5 | EX/MEM increment destination |
| exm_inc_we | input | 1 | EX/MEM increment write enable |
| exm_rd_val | input | 32 | EX/MEM primary result |
| exm_inc_val | input | 32 | EX/MEM increment result |
| mwb_rd | input | 5 | MEM/WB primary destination (write port 1) |
| mwb_rd_we | input | 1 | MEM/WB primary write enable |
| mwb_inc_rd | input | 5 | MEM/WB increment destination (write port 2) |
| mwb_inc_we | input | 1 | MEM/WB increment write enable |
| mwb_rd_val | input | 32 | MEM/WB primary result |
| mwb_inc_val | input | 32 | MEM/WB increment result |
| fwd_a | output | 3 | Operand A source code (0 none, 1 EX/MEM primary, 2 EX/MEM increment, 3 MEM/WB primary, 4 MEM/WB increment) |
| fwd_b | output | 3 | Operand B source code, same encoding |
| alu_a | output | 32 | Operand A after forwarding |
| alu_b | output | 32 | Operand B after forwarding |
| ex_inc_val | output | 32 | Base plus step from the dedicated adder |
| hold_pc | output | 1 | Hold the program counter |
| hold_ifid | output | 1 | Hold the IF/ID register |
| ex_bubble | output | 1 | Clear the write enables of the instruction entering execute |

## Verification
The forwarding selects, operands, increment sum, hold and bubble controls are all combinational. They are due in the same cycle as their stimulus, so the bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. Register-file writes commit at the rising edge and are checked on the following low phase after the write enables are dropped. The pass-through read is checked in the same low phase as the write request, before that edge.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;
  typedef enum logic [2:0] {
    SRC_IDEX    = 3'd0,
    SRC_EXM_RD  = 3'd1,
    SRC_EXM_INC = 3'd2,
    SRC_WB_RD   = 3'd3,
    SRC_WB_INC  = 3'd4
  } opnd_src_e;
endpackage

// File: rtl/hzfw_opsel.sv
module hzfw_opsel
  import hzfw_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_rd_we,
  input  logic [AW-1:0] exm_inc_rd,
  input  logic          exm_inc_we,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_rd_we,
  input  logic [AW-1:0] mwb_inc_rd,
  input  logic          mwb_inc_we,
  output opnd_src_e     sel
);
  logic live;
  assign live = (src != '0);

  always_comb begin
    sel = SRC_IDEX;
    if (live) begin
      if (exm_rd_we && exm_rd == src)          sel = SRC_EXM_RD;
      else if (exm_inc_we && exm_inc_rd == src) sel = SRC_EXM_INC;
      else if (mwb_rd_we && mwb_rd == src)     sel = SRC_WB_RD;
      else if (mwb_inc_we && mwb_inc_rd == src) sel = SRC_WB_INC;
    end
  end

  AST_ZERO_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_IDEX)); // R6
  AST_YOUNG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0 && exm_inc_we && exm_inc_rd == src) |-> (sel == SRC_EXM_RD || sel == SRC_EXM_INC)); // R5
endmodule

// File: rtl/hzfw_stall.sv
module hzfw_stall #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_rd_we,
  input  logic          ex_is_load,
  output logic          stall
);
  logic hit1, hit2;
  assign hit1  = (ex_rd == id_rs1);
  assign hit2  = (ex_rd == id_rs2);
  assign stall = ex_is_load && ex_rd_we && (ex_rd != '0) && (hit1 || hit2);

  AST_NO_STALL_UNMATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd != id_rs1 && ex_rd != id_rs2) |-> !stall); // R4
  AST_NO_STALL_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !stall); // R1
endmodule

// File: rtl/hzfw_regfile.sv
module hzfw_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   wa_idx,
  input  logic            wa_we,
  input  logic [XLEN-1:0] wa_data,
  input  logic [AW-1:0]   wb_idx,
  input  logic            wb_we,
  input  logic [XLEN-1:0] wb_data,
  input  logic [AW-1:0]   r0_idx,
  input  logic [AW-1:0]   r1_idx,
  output logic [XLEN-1:0] r0_data,
  output logic [XLEN-1:0] r1_data
);
  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wb_we && wb_idx != '0) regs[wb_idx] <= wb_data;
      if (wa_we && wa_idx != '0) regs[wa_idx] <= wa_data;
    end
  end

  function automatic logic [XLEN-1:0] rd_port(input logic [AW-1:0] idx);
    logic [XLEN-1:0] v;
    if (idx == '0)                  v = '0;
    else if (wa_we && wa_idx == idx) v = wa_data;
    else if (wb_we && wb_idx == idx) v = wb_data;
    else                             v = regs[idx];
    return v;
  endfunction

  assign r0_data = rd_port(r0_idx);
  assign r1_data = rd_port(r1_idx);

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (r0_idx == '0) |-> (r0_data == '0)); // R8
  AST_WB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_idx == r1_idx && r1_idx != '0 && !(wa_we && wa_idx == r1_idx))
      |-> (r1_data == wb_data)); // R9
  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wa_we) && $past(wa_idx) != '0 && r0_idx == $past(wa_idx)
      && !(wa_we && wa_idx == r0_idx) && !(wb_we && wb_idx == r0_idx))
      |-> (r0_data == $past(wa_data))); // R8
endmodule

// File: rtl/hzfw_top.sv
module hzfw_top
  import hzfw_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int AW       = 5,
  parameter int INC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_rs1,
  input  logic [AW-1:0]   id_rs2,
  output logic [XLEN-1:0] id_rdata1,
  output logic [XLEN-1:0] id_rdata2,
  input  logic [AW-1:0]   ex_rs1,
  input  logic [AW-1:0]   ex_rs2,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_rd_we,
  input  logic            ex_is_load,
  input  logic [XLEN-1:0] ex_rs1_val,
  input  logic [XLEN-1:0] ex_rs2_val,
  input  logic [AW-1:0]   exm_rd,
  input  logic            exm_rd_we,
  input  logic [AW-1:0]   exm_inc_rd,
  input  logic            exm_inc_we,
  input  logic [XLEN-1:0] exm_rd_val,
  input  logic [XLEN-1:0] exm_inc_val,
  input  logic [AW-1:0]   mwb_rd,
  input  logic            mwb_rd_we,
  input  logic [AW-1:0]   mwb_inc_rd,
  input  logic            mwb_inc_we,
  input  logic [XLEN-1:0] mwb_rd_val,
  input  logic [XLEN-1:0] mwb_inc_val,
  output logic [2:0]      fwd_a,
  output logic [2:0]      fwd_b,
  output logic [XLEN-1:0] alu_a,
  output logic [XLEN-1:0] alu_b,
  output logic [XLEN-1:0] ex_inc_val,
  output logic            hold_pc,
  output logic            hold_ifid,
  output logic            ex_bubble
);
  localparam int NOPND = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(INC_STEP);

  logic [AW-1:0]   op_src [NOPND];
  logic [XLEN-1:0] op_idex [NOPND];
  logic [XLEN-1:0] op_out [NOPND];
  opnd_src_e       op_sel [NOPND];
  logic            stall;

  assign op_src[0]  = ex_rs1;
  assign op_src[1]  = ex_rs2;
  assign op_idex[0] = ex_rs1_val;
  assign op_idex[1] = ex_rs2_val;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hzfw_opsel #(.AW(AW)) u_sel (
      .clk(clk), .rst_n(rst_n), .src(op_src[g]),
      .exm_rd(exm_rd), .exm_rd_we(exm_rd_we),
      .exm_inc_rd(exm_inc_rd), .exm_inc_we(exm_inc_we),
      .mwb_rd(mwb_rd), .mwb_rd_we(mwb_rd_we),
      .mwb_inc_rd(mwb_inc_rd), .mwb_inc_we(mwb_inc_we),
      .sel(op_sel[g])
    );

    always_comb begin
      unique case (op_sel[g])
        SRC_EXM_RD:  op_out[g] = exm_rd_val;
        SRC_EXM_INC: op_out[g] = exm_inc_val;
        SRC_WB_RD:   op_out[g] = mwb_rd_val;
        SRC_WB_INC:  op_out[g] = mwb_inc_val;
        default:     op_out[g] = op_idex[g];
      endcase
    end
  end

  assign fwd_a      = op_sel[0];
  assign fwd_b      = op_sel[1];
  assign alu_a      = op_out[0];
  assign alu_b      = op_out[1];
  assign ex_inc_val = op_out[0] + STEP;

  hzfw_stall #(.AW(AW)) u_stall (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_rd_we(ex_rd_we), .ex_is_load(ex_is_load),
    .stall(stall)
  );

  assign hold_pc   = stall;
  assign hold_ifid = stall;
  assign ex_bubble = stall;

  hzfw_regfile #(.XLEN(XLEN), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wa_idx(mwb_rd), .wa_we(mwb_rd_we), .wa_data(mwb_rd_val),
    .wb_idx(mwb_inc_rd), .wb_we(mwb_inc_we), .wb_data(mwb_inc_val),
    .r0_idx(id_rs1), .r1_idx(id_rs2),
    .r0_data(id_rdata1), .r1_data(id_rdata2)
  );

  AST_EXM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_rd_we && exm_rd == ex_rs1 && ex_rs1 != '0) |-> (alu_a == exm_rd_val)); // R1
  AST_WB_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_rd_we && !exm_inc_we && mwb_rd_we && mwb_rd == ex_rs2 && ex_rs2 != '0)
      |-> (alu_b == mwb_rd_val)); // R2
  AST_HOLD_BUBBLE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pc == ex_bubble) && (hold_ifid == ex_bubble)); // R3
endmodule

// File: tb/sim_hzfw_top.sv
`timescale 1ns/1ps
module sim_hzfw_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd;
  logic [4:0]  exm_rd, exm_inc_rd, mwb_rd, mwb_inc_rd;
  logic        ex_rd_we, ex_is_load, exm_rd_we, exm_inc_we, mwb_rd_we, mwb_inc_we;
  logic [31:0] ex_rs1_val, ex_rs2_val, exm_rd_val, exm_inc_val, mwb_rd_val, mwb_inc_val;
  logic [31:0] id_rdata1, id_rdata2, alu_a, alu_b, ex_inc_val;
  logic [2:0]  fwd_a, fwd_b;
  logic        hold_pc, hold_ifid, ex_bubble;

  hzfw_top u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [2:0] code, input logic [31:0] own);
    case (code)
      3'd1: return 32'h3333_0000;
      3'd2: return 32'h4444_0000;
      3'd3: return 32'h5555_0000;
      3'd4: return 32'h6666_0000;
      default: return own;
    endcase
  endfunction

  // row: rs1 rs2 | exm_rd we | exm_inc we | mwb_rd we | mwb_inc we | exp_a exp_b
  localparam int NV = 10;
  localparam logic [39:0] TBL [NV] = '{
    {5'd3, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0, 3'd0}, // R6 none
    {5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd1, 3'd0}, // R1 A
    {5'd3, 5'd4, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0, 3'd1}, // R1 B
    {5'd3, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 3'd3, 3'd0}, // R2
    {5'd3, 5'd4, 5'd0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0, 3'd2}, // R4 exm inc
    {5'd3, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 1'b1, 3'd4, 3'd0}, // R4 wb inc
    {5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 3'd1, 3'd4}, // R5 stage order
    {5'd3, 5'd4, 5'd5, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 5'd4, 1'b1, 3'd2, 3'd3}, // R5 rd before inc
    {5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 3'd0, 3'd0}, // R6 x0
    {5'd3, 5'd4, 5'd3, 1'b0, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4, 1'b0, 3'd0, 3'd0}  // R6 enables off
  };

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    ex_rd_we = 0; ex_is_load = 0;
    exm_rd = 0; exm_rd_we = 0; exm_inc_rd = 0; exm_inc_we = 0;
    mwb_rd = 0; mwb_rd_we = 0; mwb_inc_rd = 0; mwb_inc_we = 0;
    ex_rs1_val = 32'h1111_0000; ex_rs2_val = 32'h2222_0000;
    exm_rd_val = 32'h3333_0000; exm_inc_val = 32'h4444_0000;
    mwb_rd_val = 32'h5555_0000; mwb_inc_val = 32'h6666_0000;
  endtask

  task automatic hold_chk(input string tag, input logic exp);
    #1;
    chk({tag, " hold_pc"}, {31'd0, hold_pc}, {31'd0, exp});
    chk({tag, " hold_ifid"}, {31'd0, hold_ifid}, {31'd0, exp});
    chk({tag, " ex_bubble"}, {31'd0, ex_bubble}, {31'd0, exp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset state
    id_rs1 = 5'd5; id_rs2 = 5'd31;
    #1;
    chk("R10 x5 after reset", id_rdata1, 32'd0);
    chk("R10 x31 after reset", id_rdata2, 32'd0);

    // table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      {ex_rs1, ex_rs2, exm_rd, exm_rd_we, exm_inc_rd, exm_inc_we,
       mwb_rd, mwb_rd_we, mwb_inc_rd, mwb_inc_we} = TBL[i][39:6];
      #1;
      chk($sformatf("R1/R2/R4/R5/R6 fwd_a row %0d", i), {29'd0, fwd_a}, {29'd0, TBL[i][5:3]});
      chk($sformatf("R1/R2/R4/R5/R6 fwd_b row %0d", i), {29'd0, fwd_b}, {29'd0, TBL[i][2:0]});
      chk($sformatf("operand A row %0d", i), alu_a, pick(TBL[i][5:3], 32'h1111_0000));
      chk($sformatf("operand B row %0d", i), alu_b, pick(TBL[i][2:0], 32'h2222_0000));
      chk($sformatf("R7 inc adder row %0d", i), ex_inc_val, pick(TBL[i][5:3], 32'h1111_0000) + 32'd4);
      chk($sformatf("R1 no stall row %0d", i), {31'd0, hold_pc}, 32'd0);
    end

    // R7 wrap-around
    @(negedge clk); idle(); ex_rs1 = 5'd2; ex_rs1_val = 32'hFFFF_FFFE;
    #1; chk("R7 wrap", ex_inc_val, 32'h0000_0002);

    // R3 load-use
    @(negedge clk); idle(); ex_is_load = 1; ex_rd_we = 1; ex_rd = 5'd7; id_rs1 = 5'd7;
    hold_chk("R3 rs1 match", 1'b1);
    @(negedge clk); idle(); ex_is_load = 1; ex_rd_we = 1; ex_rd = 5'd7; id_rs2 = 5'd7;
    hold_chk("R3 rs2 match", 1'b1);
    @(negedge clk); idle(); ex_is_load = 0; ex_rd_we = 1; ex_rd = 5'd7; id_rs1 = 5'd7;
    hold_chk("R3 alu no stall", 1'b0);
    // R4: reader needs only the increment destination of the load
    @(negedge clk); idle(); ex_is_load = 1; ex_rd_we = 1; ex_rd = 5'd8; id_rs1 = 5'd9; id_rs2 = 5'd10;
    hold_chk("R4 inc-only no stall", 1'b0);
    // R6 load to x0
    @(negedge clk); idle(); ex_is_load = 1; ex_rd_we = 1; ex_rd = 5'd0;
    hold_chk("R6 x0 load no stall", 1'b0);

    // R9 same-cycle pass-through, then R8 commit
    @(negedge clk); idle();
    mwb_rd = 5'd5; mwb_rd_we = 1; mwb_rd_val = 32'hA5A5_0001;
    mwb_inc_rd = 5'd6; mwb_inc_we = 1; mwb_inc_val = 32'h5A5A_0002;
    id_rs1 = 5'd5; id_rs2 = 5'd6;
    #1;
    chk("R9 primary port pass", id_rdata1, 32'hA5A5_0001);
    chk("R9 increment port pass", id_rdata2, 32'h5A5A_0002);
    @(negedge clk);
    mwb_rd_we = 0; mwb_inc_we = 0; mwb_rd_val = 0; mwb_inc_val = 0;
    #1;
    chk("R8 port1 stored", id_rdata1, 32'hA5A5_0001);
    chk("R8 port2 stored", id_rdata2, 32'h5A5A_0002);

    // R9 both ports same register: primary wins
    @(negedge clk); idle();
    mwb_rd = 5'd12; mwb_rd_we = 1; mwb_rd_val = 32'h0000_00AA;
    mwb_inc_rd = 5'd12; mwb_inc_we = 1; mwb_inc_val = 32'h0000_00BB;
    id_rs1 = 5'd12;
    #1; chk("R9 dual same reg", id_rdata1, 32'h0000_00AA);
    @(negedge clk); mwb_rd_we = 0; mwb_inc_we = 0;
    #1; chk("R8 dual same reg stored", id_rdata1, 32'h0000_00AA);

    // R8 x0 writes discarded on both ports
    @(negedge clk); idle();
    mwb_rd = 5'd0; mwb_rd_we = 1; mwb_rd_val = 32'hDEAD_BEEF;
    mwb_inc_rd = 5'd0; mwb_inc_we = 1; mwb_inc_val = 32'hCAFE_F00D;
    #1; chk("R8 x0 read during write", id_rdata1, 32'd0);
    @(negedge clk); mwb_rd_we = 0; mwb_inc_we = 0;
    #1;
    chk("R8 x0 after write port1", id_rdata1, 32'd0);
    chk("R8 x0 after write port2", id_rdata2, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule